// File: doc/BRIEF.md
# Machine-Mode Timer with Debug Pause

This block keeps a free-running 64-bit machine-mode time value and a 64-bit compare value, and raises a timer interrupt whenever the time has reached the compare value. Software reaches both 64-bit quantities as pairs of 32-bit halves through a small synchronous write port and a combinational read port. A 4-bit control register starts or stops the count and picks the count rate. The count can advance on every clock, or only on clocks where an external tick pulse is high. The control register can also freeze the count while a debugger holds either of two cores halted.

Reset leaves the timer enabled in tick mode, with both debug pauses armed. The count resets to zero and the compare value to all ones, so the interrupt stays low after power-up until software programs a compare value.

Top module: `mtimer_top`

## Requirements
- R1: After reset the control register reads 0x0000000D, both count halves read 0, both compare halves read 0xFFFFFFFF, and `irq` is low.
- R2: The register address selects the control register at 0, the low count half at 1, the high count half at 2, the low compare half at 3 and the high compare half at 4. The control register reads zero-extended. Any other address reads 0.
- R3: When control bit 0 (run) is set and control bit 1 (fast) is set, the count rises by one on every clock.
- R4: When run is set and fast is clear, the count rises by one only on clocks where `tick` is high.
- R5: When run is clear, the count holds its value whatever `tick` does.
- R6: When control bit 2 is set, the count holds while `halt0` is high. When control bit 3 is set, the count holds while `halt1` is high. A halt input whose pause bit is clear has no effect.
- R7: When the low count half steps from 0xFFFFFFFF, it becomes 0 and the high half rises by one on the same clock edge.
- R8: A write to either count half loads that half and suppresses the increment for that clock. The other half keeps its value.
- R9: `irq` is high exactly when the 64-bit count is greater than or equal to the 64-bit compare value, compared unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | Count pulse used when fast mode is off |
| halt0 | input | 1 | Core 0 is in debug halt |
| halt1 | input | 1 | Core 1 is in debug halt |
| irq | output | 1 | Timer interrupt, count >= compare |

## Verification
The count gate is tried with a table of combinations of the run bit, the fast bit, the level of `tick`, the two halt inputs and the two pause bits. Each row tells a gating term that is wired in apart from one that is missing or inverted: a constant-high tick separates tick mode from a stuck hold, a halt whose pause bit is clear separates a pause that is masked correctly from one that is not, and a pause bit set for one core with only the other core halted shows that the cores are not crossed. A sparse tick pattern shows that tick mode counts pulses and not clocks. Preloading the count near the top of the low half exposes a carry that is missing or one cycle late. A count and a compare value that differ only in the high half show that the compare covers all 64 bits.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;

  // Control field, bit 0 = run .. bit 3 = pause on core 1 halt
  typedef struct packed {
    logic pause1;
    logic pause0;
    logic fast;
    logic run;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pause1: 1'b1, pause0: 1'b1, fast: 1'b0, run: 1'b1};

  // One count step is allowed this cycle
  function automatic logic step_ok(ctrl_t c, logic tick, logic h0, logic h1);
    logic rate_hit;
    logic frozen;
    rate_hit = c.fast | tick;
    frozen   = (c.pause0 & h0) | (c.pause1 & h1);
    return c.run & rate_hit & ~frozen;
  endfunction

endpackage

// File: rtl/mtimer_ctrl_regs.sv
module mtimer_ctrl_regs
  import mtimer_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic [HALF_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic [2*HALF_W-1:0] cmp_q
);

  localparam int CW = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl)   ctrl_q <= ctrl_t'(wdata[CW-1:0]);
      if (wr_cmp_lo) cmp_q[HALF_W-1:0] <= wdata;
      if (wr_cmp_hi) cmp_q[2*HALF_W-1:HALF_W] <= wdata;
    end
  end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] count_q,
  output logic                lo_wrap
);

  logic [HALF_W-1:0] lo_q, hi_q;
  logic              any_wr;

  assign any_wr  = wr_lo | wr_hi;
  assign lo_wrap = advance & ~any_wr & (&lo_q);
  assign count_q = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else if (advance) begin
      lo_q <= lo_q + 1'b1;
      if (lo_wrap) hi_q <= hi_q + 1'b1;
    end
  end

endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare #(
  parameter int W = 64
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  output logic         reached
);

  assign reached = (count >= cmp);

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [HALF_W-1:0]     wdata,
  output logic [HALF_W-1:0]     rdata,
  input  logic                  tick,
  input  logic                  halt0,
  input  logic                  halt1,
  output logic                  irq
);

  localparam int FULL_W = 2 * HALF_W;
  localparam int CW     = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [FULL_W-1:0] cmp_q;
  logic [FULL_W-1:0] count_q;
  logic              wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  logic              advance;
  logic              lo_wrap;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_cnt_lo = wr_en && (addr == A_CNT_LO);
  assign wr_cnt_hi = wr_en && (addr == A_CNT_HI);
  assign wr_cmp_lo = wr_en && (addr == A_CMP_LO);
  assign wr_cmp_hi = wr_en && (addr == A_CMP_HI);

  assign advance = step_ok(ctrl_q, tick, halt0, halt1);

  mtimer_ctrl_regs #(.HALF_W(HALF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_cmp_lo (wr_cmp_lo),
    .wr_cmp_hi (wr_cmp_hi),
    .wdata     (wdata),
    .ctrl_q    (ctrl_q),
    .cmp_q     (cmp_q)
  );

  mtimer_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .wr_lo   (wr_cnt_lo),
    .wr_hi   (wr_cnt_hi),
    .wdata   (wdata),
    .count_q (count_q),
    .lo_wrap (lo_wrap)
  );

  mtimer_compare #(.W(FULL_W)) u_cmp (
    .count   (count_q),
    .cmp     (cmp_q),
    .reached (irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CW-1:0] = ctrl_q;
      A_CNT_LO: rdata = count_q[HALF_W-1:0];
      A_CNT_HI: rdata = count_q[FULL_W-1:HALF_W];
      A_CMP_LO: rdata = cmp_q[HALF_W-1:0];
      A_CMP_HI: rdata = cmp_q[FULL_W-1:HALF_W];
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int HALF_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  advance,
  input logic                  wr_cnt_lo,
  input logic                  wr_cnt_hi,
  input logic                  lo_wrap,
  input logic [HALF_W-1:0]     wdata,
  input logic [2*HALF_W-1:0]   count_q,
  input logic [2*HALF_W-1:0]   cmp_q,
  input logic                  irq
);

  localparam int FULL_W = 2 * HALF_W;

  // R5, R6: no step and no write leaves the count unchanged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !wr_cnt_lo && !wr_cnt_hi) |=> count_q == $past(count_q));

  // R3, R4: a step raises the full count by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_cnt_lo && !wr_cnt_hi) |=> count_q == $past(count_q) + 1'b1);

  // R7: low wrap carries into the high half on the same edge
  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (count_q[HALF_W-1:0] == '0) &&
                (count_q[FULL_W-1:HALF_W] == $past(count_q[FULL_W-1:HALF_W]) + 1'b1));

  // R8: a low-half write wins and the high half stays
  p_wrlo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_lo && !wr_cnt_hi) |=> (count_q[HALF_W-1:0] == $past(wdata)) &&
                                  (count_q[FULL_W-1:HALF_W] == $past(count_q[FULL_W-1:HALF_W])));

  // R8: a high-half write wins and the low half stays
  p_wrhi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_hi && !wr_cnt_lo) |=> (count_q[FULL_W-1:HALF_W] == $past(wdata)) &&
                                  (count_q[HALF_W-1:0] == $past(count_q[HALF_W-1:0])));

  // R9: interrupt follows the unsigned relation
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (count_q >= cmp_q));

endmodule

bind mtimer_top mtimer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .advance   (advance),
  .wr_cnt_lo (wr_cnt_lo),
  .wr_cnt_hi (wr_cnt_hi),
  .lo_wrap   (lo_wrap),
  .wdata     (wdata),
  .count_q   (count_q),
  .cmp_q     (cmp_q),
  .irq       (irq)
);

// File: tb/tb_mtimer_top.sv
module tb_mtimer_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0, halt0 = 1'b0, halt1 = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  mtimer_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .halt0(halt0), .halt1(halt1), .irq(irq)
  );

  // ctrl bits: 0 run, 1 fast, 2 pause core0, 3 pause core1
  typedef struct packed {
    logic [3:0] ctrl;
    logic       tk;
    logic       h0;
    logic       h1;
    logic [7:0] expect_n;
  } vec_t;

  localparam int RUN_N = 10;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'b0011, 1'b0, 1'b0, 1'b0, 8'd10},  // R3 fast
    '{4'b0001, 1'b1, 1'b0, 1'b0, 8'd10},  // R4 tick held high
    '{4'b0001, 1'b0, 1'b0, 1'b0, 8'd0},   // R4 no tick
    '{4'b0010, 1'b1, 1'b0, 1'b0, 8'd0},   // R5 run clear
    '{4'b0111, 1'b0, 1'b1, 1'b0, 8'd0},   // R6 core0 paused
    '{4'b1011, 1'b0, 1'b0, 1'b1, 8'd0},   // R6 core1 paused
    '{4'b0011, 1'b0, 1'b1, 1'b1, 8'd10},  // R6 pauses masked
    '{4'b0111, 1'b0, 1'b0, 1'b1, 8'd10},  // R6 cores not crossed
    '{4'b1111, 1'b1, 1'b1, 1'b0, 8'd0}    // R6 both armed, core0 halted
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);

    // R1 reset values, R2 address map
    rd(3'd0, v); check("R1 ctrl", v, 32'h0000000D);
    rd(3'd1, v); check("R1 cnt_lo", v, 32'h0);
    rd(3'd2, v); check("R1 cnt_hi", v, 32'h0);
    rd(3'd3, v); check("R1 cmp_lo", v, 32'hFFFFFFFF);
    rd(3'd4, v); check("R1 cmp_hi", v, 32'hFFFFFFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, v); check("R2 unused addr 5", v, 32'h0);
    rd(3'd7, v); check("R2 unused addr 7", v, 32'h0);
    wr(3'd3, 32'h12345678);
    rd(3'd3, v); check("R2 cmp_lo readback", v, 32'h12345678);
    rd(3'd4, v); check("R2 cmp_hi untouched", v, 32'hFFFFFFFF);
    wr(3'd3, 32'hFFFFFFFF);

    // Gating table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {28'b0, VECS[i].ctrl});
      tick = VECS[i].tk; halt0 = VECS[i].h0; halt1 = VECS[i].h1;
      wr(3'd2, 32'h0);
      wr(3'd1, 32'h0);
      repeat (RUN_N) @(negedge clk);
      rd(3'd1, v);
      check($sformatf("R3/R4/R5/R6 vector %0d", i), v, {24'b0, VECS[i].expect_n});
    end
    tick = 0; halt0 = 0; halt1 = 0;

    // R4 sparse ticks: 4 pulses over 12 clocks
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0);
    for (int c = 0; c < 12; c++) begin
      tick = (c % 3 == 0);
      @(negedge clk);
    end
    tick = 0;
    rd(3'd1, v); check("R4 sparse ticks", v, 32'd4);

    // R7 carry
    wr(3'd0, 32'h3);
    wr(3'd2, 32'h5);
    wr(3'd1, 32'hFFFFFFFE);
    @(negedge clk);
    rd(3'd1, v); check("R7 lo at top", v, 32'hFFFFFFFF);
    rd(3'd2, v); check("R7 hi before wrap", v, 32'h5);
    @(negedge clk);
    rd(3'd1, v); check("R7 lo wrapped", v, 32'h0);
    rd(3'd2, v); check("R7 hi carried", v, 32'h6);

    // R8 write priority while counting at full speed
    wr(3'd1, 32'd100);
    rd(3'd1, v); check("R8 lo load wins", v, 32'd100);
    rd(3'd1, v2);
    wr(3'd2, 32'd7);
    rd(3'd1, v); check("R8 lo held on hi write", v, v2);
    rd(3'd2, v); check("R8 hi loaded", v, 32'd7);

    // R9 interrupt compare, counting stopped
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'd10);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'd11);
    check("R9 below", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'd10);
    check("R9 equal", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'd9);
    check("R9 above", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h0);
    wr(3'd3, 32'hFFFFFFFF);
    check("R9 high half decides", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h2);
    check("R9 high cmp above", {31'b0, irq}, 32'h0);
    rd(3'd1, v); check("R5 held while stopped", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule